// File: doc/BRIEF.md
# Turbo Clock Switch Controller

This block produces the clock for the CPU of a two-speed computer. It also drives the ready (hold) line of that CPU. Out of reset the CPU runs from the slow bus clock, which the video controller owns. When the turbo bit is set, the CPU moves to a fast clock that is independent of the slow one. While in turbo mode, any valid CPU access to slow-device address space drops the ready line at once. The block then swaps the CPU over to the slow clock at a safe phase and releases ready for one slow bus cycle. After that it holds ready again, swaps back to the fast clock and releases ready.

Clock selection uses a two-leg glitch-free mux. Each leg has a reset synchroniser and a two-flop enable synchroniser in its own clock domain. Each leg gates its clock with an enable that changes only while that clock is low, and a leg turns on only after the other leg has been seen off. The control state machine runs in the fast domain and waits for the acknowledge of each leg before it releases ready. In slow mode, an access to slow-device space is held off while the video controller owns the bus. Slow-device space is a set of base/mask address windows.

Top module: `turbo_clk_ctl`

## Requirements
- R1: While reset is held and after reset with turbo clear, `fast_active` is 0 and `cpu_clk` follows `clk_slow`. During reset, `cpu_clk` is 0.
- R2: When `turbo_en` is 1, the block ends in a state with `fast_active` = 1, `cpu_rdy` = 1 and `cpu_clk` following `clk_fast`.
- R3: The two clock legs are never enabled at the same time. Every high or low pulse of `cpu_clk` lasts at least half a fast-clock period.
- R4: In fast mode, `cpu_rdy` drops in the same fast cycle as a valid access (`cpu_vda` = 1) to slow-device space. An access outside that space, or one with `cpu_vda` = 0, leaves `cpu_rdy` at 1.
- R5: `cpu_rdy` is 0 whenever `fast_active` changes, both into and out of fast mode.
- R6: On a slow-device access from fast mode, `cpu_rdy` returns to 1 only with the slow leg on and the fast leg off. It then stays at 1 for at least half a slow-clock period, covering one rise and fall of the slow clock. After that `cpu_rdy` drops, the fast clock is restored (`fast_active` = 1), and `cpu_rdy` returns to 1.
- R7: Clearing `turbo_en` in fast mode goes through the same hold-and-swap sequence into slow mode. The block then stays there (`fast_active` = 0), and slow-device accesses made while `video_busy` = 0 do not stall.
- R8: In slow mode, a valid slow-device access while `video_busy` = 1 holds `cpu_rdy` at 0 until `video_busy` returns to 0.
- R9: An address is slow-device space when (addr & mask) == base for any window. The default windows are A000–BFFF, D000–DFFF and E000–FFFF. So 9FFF, C000 and CFFF are outside this space, and A000, BFFF, D000 and FFFF are inside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock, free-running |
| clk_slow | input | 1 | Slow bus clock owned by the video controller |
| rst_n | input | 1 | Asynchronous active-low reset |
| turbo_en | input | 1 | Turbo request bit from the processor port |
| cpu_addr | input | AW | CPU address |
| cpu_vda | input | 1 | CPU address valid strobe |
| video_busy | input | 1 | Video controller currently holds the slow bus |
| cpu_clk | output | 1 | Glitch-free selected CPU clock |
| cpu_rdy | output | 1 | Ready line to the CPU, 0 holds it |
| fast_active | output | 1 | 1 while the fast leg drives `cpu_clk` |

## Verification
The assertions assume that `cpu_addr`, `cpu_vda`, `video_busy` and `turbo_en` change only in the fast clock domain, away from its rising edge. They also assume that both clocks run throughout. The bench drives every input on the falling edge of the fast clock and samples one nanosecond later. Its slow clock has a period that is not a multiple of the fast period, so the swaps land at many different phases. During a stalled access the bench keeps the address valid until `cpu_rdy` drops at the end of the slow cycle, as a held CPU would.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  typedef enum logic [2:0] {
    ST_SLOW    = 3'd0,
    ST_TO_FAST = 3'd1,
    ST_FAST    = 3'd2,
    ST_TO_SLOW = 3'd3,
    ST_ACCESS  = 3'd4
  } tcs_state_e;
endpackage

// File: rtl/tcs_addr_match.sv
module tcs_addr_match #(
  parameter int AW = 16,
  parameter int NWIN = 3,
  parameter logic [NWIN*AW-1:0] WIN_BASE = {16'hE000, 16'hD000, 16'hA000},
  parameter logic [NWIN*AW-1:0] WIN_MASK = {16'hE000, 16'hF000, 16'hE000}
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);
  logic [NWIN-1:0] win_hit;

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    assign win_hit[i] = ((addr & WIN_MASK[i*AW +: AW]) == WIN_BASE[i*AW +: AW]);
  end

  assign hit = |win_hit;
endmodule

// File: rtl/tcs_clk_leg.sv
module tcs_clk_leg (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic other_on,
  output logic clk_out,
  output logic gate
);
  logic rst_q1, rst_q2;
  logic en_s1, en_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_s1 <= 1'b0;
      en_s2 <= 1'b0;
    end else if (!rst_q2) begin
      en_s1 <= 1'b0;
      en_s2 <= 1'b0;
    end else begin
      en_s1 <= req & ~other_on;
      en_s2 <= en_s1;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate <= 1'b0;
    else        gate <= en_s2;
  end

  assign clk_out = clk & gate;
endmodule

// File: rtl/tcs_fsm.sv
module tcs_fsm
  import tcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic turbo_en,
  input  logic cpu_vda,
  input  logic slow_hit,
  input  logic video_busy,
  input  logic fast_gate,
  input  logic slow_gate,
  input  logic slow_clk_lvl,
  output logic want_fast,
  output logic cpu_rdy
);
  tcs_state_e state, state_nx;
  logic rr1, rr2;
  logic tq1, tq2;
  logic sa1, slow_ack;
  logic ck1, ck2, ck3;
  logic seen_rise, seen_rise_nx;
  logic slow_rise, slow_fall, req_slow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr1 <= 1'b0;
      rr2 <= 1'b0;
    end else begin
      rr1 <= 1'b1;
      rr2 <= rr1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tq1 <= 1'b0; tq2 <= 1'b0;
      sa1 <= 1'b0; slow_ack <= 1'b0;
      ck1 <= 1'b0; ck2 <= 1'b0; ck3 <= 1'b0;
    end else begin
      tq1 <= turbo_en;   tq2 <= tq1;
      sa1 <= slow_gate;  slow_ack <= sa1;
      ck1 <= slow_clk_lvl; ck2 <= ck1; ck3 <= ck2;
    end
  end

  assign slow_rise = ck2 & ~ck3;
  assign slow_fall = ~ck2 & ck3;
  assign req_slow  = cpu_vda & slow_hit;

  always_comb begin
    state_nx     = state;
    seen_rise_nx = 1'b0;
    unique case (state)
      ST_SLOW:    if (tq2) state_nx = ST_TO_FAST;
      ST_TO_FAST: if (fast_gate && !slow_ack) state_nx = ST_FAST;
      ST_FAST:    if (!tq2 || req_slow) state_nx = ST_TO_SLOW;
      ST_TO_SLOW: if (slow_ack && !fast_gate) state_nx = tq2 ? ST_ACCESS : ST_SLOW;
      ST_ACCESS: begin
        seen_rise_nx = seen_rise | slow_rise;
        if (seen_rise && slow_fall) begin
          state_nx     = tq2 ? ST_TO_FAST : ST_SLOW;
          seen_rise_nx = 1'b0;
        end
      end
      default:    state_nx = ST_SLOW;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_SLOW;
      want_fast <= 1'b0;
      seen_rise <= 1'b0;
    end else if (!rr2) begin
      state     <= ST_SLOW;
      want_fast <= 1'b0;
      seen_rise <= 1'b0;
    end else begin
      state     <= state_nx;
      want_fast <= (state_nx == ST_FAST) || (state_nx == ST_TO_FAST);
      seen_rise <= seen_rise_nx;
    end
  end

  always_comb begin
    unique case (state)
      ST_SLOW:   cpu_rdy = ~(req_slow & video_busy);
      ST_FAST:   cpu_rdy = tq2 & ~req_slow;
      ST_ACCESS: cpu_rdy = 1'b1;
      default:   cpu_rdy = 1'b0;
    endcase
  end

  // R6: the slow access window runs only on the slow leg
  a_r6_access_on_slow_leg: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACCESS) |-> (slow_ack && !fast_gate));

  // R8: video ownership holds a slow-mode access
  a_r8_video_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLOW && req_slow && video_busy) |-> !cpu_rdy);
endmodule

// File: rtl/turbo_clk_ctl.sv
module turbo_clk_ctl #(
  parameter int AW = 16,
  parameter int NWIN = 3,
  parameter logic [NWIN*AW-1:0] WIN_BASE = {16'hE000, 16'hD000, 16'hA000},
  parameter logic [NWIN*AW-1:0] WIN_MASK = {16'hE000, 16'hF000, 16'hE000}
) (
  input  logic          clk_fast,
  input  logic          clk_slow,
  input  logic          rst_n,
  input  logic          turbo_en,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_vda,
  input  logic          video_busy,
  output logic          cpu_clk,
  output logic          cpu_rdy,
  output logic          fast_active
);
  logic slow_hit, want_fast;
  logic fast_gate, slow_gate;
  logic fast_leg_clk, slow_leg_clk;

  tcs_addr_match #(.AW(AW), .NWIN(NWIN), .WIN_BASE(WIN_BASE), .WIN_MASK(WIN_MASK)) dec_i (
    .addr(cpu_addr), .hit(slow_hit));

  tcs_clk_leg fast_leg_i (
    .clk(clk_fast), .rst_n(rst_n), .req(want_fast), .other_on(slow_gate),
    .clk_out(fast_leg_clk), .gate(fast_gate));

  tcs_clk_leg slow_leg_i (
    .clk(clk_slow), .rst_n(rst_n), .req(~want_fast), .other_on(fast_gate),
    .clk_out(slow_leg_clk), .gate(slow_gate));

  tcs_fsm fsm_i (
    .clk(clk_fast), .rst_n(rst_n), .turbo_en(turbo_en), .cpu_vda(cpu_vda),
    .slow_hit(slow_hit), .video_busy(video_busy), .fast_gate(fast_gate),
    .slow_gate(slow_gate), .slow_clk_lvl(clk_slow), .want_fast(want_fast),
    .cpu_rdy(cpu_rdy));

  assign cpu_clk     = fast_leg_clk | slow_leg_clk;
  assign fast_active = fast_gate;

  // R3: legs never overlap
  a_r3_legs_exclusive: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !(fast_gate && slow_gate));

  // R5: ready held across every change of the fast leg
  a_r5_rdy_low_on_swap: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !$stable(fast_gate) |-> !cpu_rdy);

  // R4: a valid slow-device access on the fast clock stalls at once
  a_r4_stall_on_hit: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (fast_gate && cpu_vda && slow_hit) |-> !cpu_rdy);
endmodule

// File: tb/turbo_clk_ctl_tb_top.sv
`timescale 1ns/100ps
module turbo_clk_ctl_tb_top;
  localparam real FAST_HALF = 5.0;
  localparam real SLOW_HALF = 28.5;

  logic clk_fast = 1'b0, clk_slow = 1'b0, rst_n;
  logic turbo_en, cpu_vda, video_busy;
  logic [15:0] cpu_addr;
  logic cpu_clk, cpu_rdy, fast_active;

  int checks = 0, fails = 0;
  int pulse_viol = 0, swap_viol = 0;
  bit done = 0;
  realtime last_edge = 0.0;

  always #(FAST_HALF) clk_fast = ~clk_fast;
  initial begin #3; forever #(SLOW_HALF) clk_slow = ~clk_slow; end

  turbo_clk_ctl dut_i (
    .clk_fast(clk_fast), .clk_slow(clk_slow), .rst_n(rst_n), .turbo_en(turbo_en),
    .cpu_addr(cpu_addr), .cpu_vda(cpu_vda), .video_busy(video_busy),
    .cpu_clk(cpu_clk), .cpu_rdy(cpu_rdy), .fast_active(fast_active));

  always @(cpu_clk) begin
    if (rst_n === 1'b1) begin
      if ($realtime - last_edge < FAST_HALF) pulse_viol++;
      last_edge = $realtime;
    end
  end

  always @(fast_active) begin
    if (rst_n === 1'b1 && cpu_rdy !== 1'b0) swap_viol++;
  end

  function automatic bit exp_hit(input logic [15:0] a);
    return (a >= 16'hA000 && a <= 16'hBFFF) || (a >= 16'hD000);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_rdy(input logic v, input string tag);
    int n = 0;
    do begin @(negedge clk_fast); #1; n++; end while (cpu_rdy !== v && n < 3000);
    chk(cpu_rdy === v, tag, cpu_rdy, v);
  endtask

  task automatic follow_fast(input string tag);
    bit ok;
    @(posedge clk_fast); #2; ok = (cpu_clk === 1'b1);
    @(negedge clk_fast); #2; ok &= (cpu_clk === 1'b0);
    chk(ok, tag, ok, 1);
  endtask

  task automatic follow_slow(input string tag);
    bit ok;
    @(posedge clk_slow); #2; ok = (cpu_clk === 1'b1);
    @(negedge clk_slow); #2; ok &= (cpu_clk === 1'b0);
    chk(ok, tag, ok, 1);
  endtask

  // Completes one stalled access; cpu_rdy is already 0
  task automatic slow_access(input string tag);
    realtime t1, t2;
    wait_rdy(1'b1, {tag, " R6 release"});
    chk(fast_active === 1'b0, {tag, " R6 slow leg on release"}, fast_active, 0);
    t1 = $realtime;
    wait_rdy(1'b0, {tag, " R6 end of slow cycle"});
    t2 = $realtime;
    chk((t2 - t1) >= SLOW_HALF, {tag, " R6 slow cycle length"}, int'(t2 - t1), int'(SLOW_HALF));
    cpu_vda = 1'b0;
    wait_rdy(1'b1, {tag, " R6 return release"});
    chk(fast_active === 1'b1, {tag, " R6 fast restored"}, fast_active, 1);
  endtask

  task automatic try_access(input logic [15:0] a, input logic v, input string tag);
    bit h;
    @(negedge clk_fast);
    cpu_addr = a; cpu_vda = v;
    #1;
    h = v && exp_hit(a);
    chk(cpu_rdy === !h, {tag, " R4 R9 immediate ready"}, cpu_rdy, !h);
    if (h) slow_access(tag);
    else begin
      @(negedge clk_fast); cpu_vda = 1'b0;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; turbo_en = 1'b0; cpu_vda = 1'b0; video_busy = 1'b0; cpu_addr = 16'h0000;
    #80;
    chk(fast_active === 1'b0, "R1 reset fast_active", fast_active, 0);
    chk(cpu_clk === 1'b0, "R1 reset cpu_clk", cpu_clk, 0);
    @(negedge clk_fast); rst_n = 1'b1;
    repeat (40) @(negedge clk_fast);
    #1;
    chk(fast_active === 1'b0, "R1 slow after reset", fast_active, 0);
    chk(cpu_rdy === 1'b1, "R1 ready after reset", cpu_rdy, 1);
    follow_slow("R1 cpu_clk follows slow");

    // R8 video ownership in slow mode
    @(negedge clk_fast); cpu_addr = 16'hD012; cpu_vda = 1'b1; video_busy = 1'b1;
    #1; chk(cpu_rdy === 1'b0, "R8 hold while video busy", cpu_rdy, 0);
    repeat (5) @(negedge clk_fast);
    #1; chk(cpu_rdy === 1'b0, "R8 still held", cpu_rdy, 0);
    @(negedge clk_fast); video_busy = 1'b0;
    #1; chk(cpu_rdy === 1'b1, "R8 release after video", cpu_rdy, 1);
    @(negedge clk_fast); cpu_vda = 1'b0;

    // R2 turbo on
    @(negedge clk_fast); turbo_en = 1'b1;
    wait_rdy(1'b0, "R2 hold on swap to fast");
    wait_rdy(1'b1, "R2 release on fast");
    chk(fast_active === 1'b1, "R2 fast active", fast_active, 1);
    follow_fast("R2 cpu_clk follows fast");

    // R4 R9 directed windows and boundaries
    try_access(16'h9FFF, 1'b1, "dir 9FFF");
    try_access(16'hA000, 1'b1, "dir A000");
    try_access(16'hBFFF, 1'b1, "dir BFFF");
    try_access(16'hC000, 1'b1, "dir C000");
    try_access(16'hCFFF, 1'b1, "dir CFFF");
    try_access(16'hD000, 1'b1, "dir D000");
    try_access(16'hFFFF, 1'b1, "dir FFFF");
    try_access(16'hD400, 1'b0, "dir no strobe");
    chk(fast_active === 1'b1, "R4 still fast", fast_active, 1);

    // random mix
    for (int i = 0; i < 40; i++) begin
      logic [15:0] a;
      logic v;
      case ($urandom_range(0, 3))
        0: a = 16'hA000 + 16'($urandom_range(0, 1)) * 16'h2000 - 16'($urandom_range(0, 1));
        1: a = 16'hD000 - 16'($urandom_range(0, 1));
        default: a = 16'($urandom_range(0, 65535));
      endcase
      v = ($urandom_range(0, 3) != 0);
      try_access(a, v, "rand");
    end
    follow_fast("R2 fast after random");

    // R7 turbo cleared
    @(negedge clk_fast); turbo_en = 1'b0;
    wait_rdy(1'b0, "R7 hold on swap to slow");
    wait_rdy(1'b1, "R7 release in slow");
    chk(fast_active === 1'b0, "R7 slow leg active", fast_active, 0);
    @(negedge clk_fast); cpu_addr = 16'hE123; cpu_vda = 1'b1;
    #1; chk(cpu_rdy === 1'b1, "R7 no stall in slow mode", cpu_rdy, 1);
    repeat (30) @(negedge clk_fast);
    #1; chk(fast_active === 1'b0, "R7 stays slow", fast_active, 0);
    chk(cpu_rdy === 1'b1, "R7 still ready", cpu_rdy, 1);
    follow_slow("R7 cpu_clk follows slow");
    @(negedge clk_fast); cpu_vda = 1'b0;

    repeat (10) @(negedge clk_fast);
    chk(pulse_viol == 0, "R3 minimum pulse width", pulse_viol, 0);
    chk(swap_viol == 0, "R5 ready low on every swap", swap_viol, 0);
    finish_run();
  end
endmodule